// File: doc/BRIEF.md
# Next-PC Branch Resolver

This block decides where a processor with fixed 16-bit instructions fetches next. Each cycle it takes the current program counter (a byte address), a four-bit branch-kind code, a signed word displacement and the four condition flags. From these it produces the following program counter and a flag that says whether a branch was taken. Both results are registered and appear one clock after the inputs.

A conditional branch tests one condition built from the flags. It uses the low nine bits of the displacement field as a signed word count. The unconditional branch is always taken and uses all ten bits. In both cases the displacement is doubled to turn words into bytes. It is then added to the address of the instruction after the branch, which is PC + 2, and the sum wraps modulo 2^16. Instructions that are not branches, and branches that fail their test, both go on to PC + 2.

Top module: `pcb_next_pc`

## Requirements
- R1: Both outputs are registered. `next_pc_o` and `taken_o` show the result for the inputs present at the previous rising clock edge. While the synchronous active-high `rst` is high, at an edge they are loaded with 0.
- R2: Kind codes 0, 14 and 15 are not branches. They give `taken_o` = 0 and `next_pc_o` = PC + 2.
- R3: For a conditional kind (codes 1 to 12) that is taken, the target is PC + 2 + 2 × sext(`offset_i[8:0]`). This covers -256 to +255 words. `offset_i[9]` has no effect on conditional kinds.
- R4: Kind code 13 is the unconditional branch. It is always taken, whatever the flags. Its target is PC + 2 + 2 × sext(`offset_i[9:0]`), which covers -512 to +511 words.
- R5: `flags_i` carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Code 1 (equal) is taken exactly when Z = 1, and code 2 (not equal) exactly when Z = 0.
- R6: The single-flag codes are taken as follows: code 3 when C = 1, code 4 when C = 0, code 5 when N = 1, code 6 when N = 0, code 7 when V = 1 and code 8 when V = 0.
- R7: The signed comparisons are taken as follows: code 9 (greater or equal) when N xor V = 0, code 10 (less) when N xor V = 1, code 11 (greater) when Z = 0 and N xor V = 0, and code 12 (less or equal) when Z = 1 or N xor V = 1.
- R8: A conditional branch whose test fails gives `taken_o` = 0 and `next_pc_o` = PC + 2.
- R9: Bit 0 of `pc_i` is ignored, so an odd PC behaves like the even address just below it. Bit 0 of `next_pc_o` is always 0.
- R10: All address arithmetic wraps modulo 2^16. Branching forward past 0xFFFE wraps to low addresses, and branching backward past 0 wraps to high addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 16 | Current program counter (byte address) |
| kind_i | input | 4 | Branch-kind code (see R2 to R7) |
| offset_i | input | 10 | Signed word displacement field |
| flags_i | input | 4 | Condition flags {N, Z, V, C} |
| next_pc_o | output | 16 | Registered next program counter |
| taken_o | output | 1 | Registered branch-taken indication |

## Verification
Every result has one register between the inputs and the ports, so each result is due exactly one clock after its stimulus. The bench applies a stimulus on a falling edge and stores the model's prediction in a queue. On the next falling edge it pops that prediction and compares it with the outputs. The sample point therefore lies half a period after the edge that loads the result and before the next stimulus is applied. The reset value is read on a falling edge while `rst` is still high.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int ADDR_W     = 16;
    localparam int INSN_BYTES = 2;
    localparam int COND_OFS_W = 9;
    localparam int JUMP_OFS_W = 10;
    localparam int KIND_W     = 4;
    localparam int FLAG_W     = 4;

    typedef enum logic [KIND_W-1:0] {
        BK_NONE   = 4'd0,
        BK_EQ     = 4'd1,
        BK_NE     = 4'd2,
        BK_CS     = 4'd3,
        BK_CC     = 4'd4,
        BK_MI     = 4'd5,
        BK_PL     = 4'd6,
        BK_VS     = 4'd7,
        BK_VC     = 4'd8,
        BK_GE     = 4'd9,
        BK_LT     = 4'd10,
        BK_GT     = 4'd11,
        BK_LE     = 4'd12,
        BK_ALWAYS = 4'd13
    } br_kind_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] pc;
    } npc_res_t;

    function automatic logic kind_is_cond(input br_kind_e k);
        return (k >= BK_EQ) && (k <= BK_LE);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcb_cond_unit.sv
module pcb_cond_unit
    import pcb_pkg::*;
(
    input  br_kind_e kind,
    input  ccr_t     ccr,
    output logic     is_cond,
    output logic     cond_ok
);
    logic lt_signed;

    assign lt_signed = ccr.neg ^ ccr.ovf;
    assign is_cond   = kind_is_cond(kind);

    always_comb begin
        unique case (kind)
            BK_EQ:   cond_ok = ccr.zero;
            BK_NE:   cond_ok = !ccr.zero;
            BK_CS:   cond_ok = ccr.carry;
            BK_CC:   cond_ok = !ccr.carry;
            BK_MI:   cond_ok = ccr.neg;
            BK_PL:   cond_ok = !ccr.neg;
            BK_VS:   cond_ok = ccr.ovf;
            BK_VC:   cond_ok = !ccr.ovf;
            BK_GE:   cond_ok = !lt_signed;
            BK_LT:   cond_ok = lt_signed;
            BK_GT:   cond_ok = !ccr.zero && !lt_signed;
            BK_LE:   cond_ok = ccr.zero || lt_signed;
            default: cond_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcb_offset_scaler.sv
module pcb_offset_scaler #(
    parameter int IN_W  = 9,
    parameter int SHIFT = 1,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  ofs_words,
    output logic [OUT_W-1:0] ofs_bytes
);
    localparam int FULL_W = IN_W + SHIFT;

    generate
        if (OUT_W >= FULL_W) begin : g_extend
            assign ofs_bytes = {{(OUT_W-FULL_W){ofs_words[IN_W-1]}},
                                ofs_words, {SHIFT{1'b0}}};
        end else begin : g_trunc
            logic [FULL_W-1:0] wide;
            assign wide      = {ofs_words, {SHIFT{1'b0}}};
            assign ofs_bytes = wide[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pcb_addr_adder.sv
module pcb_addr_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    assign sum = a + b;
endmodule

// File: rtl/pcb_next_pc.sv
module pcb_next_pc
    import pcb_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int IB    = INSN_BYTES,
    parameter int COW   = COND_OFS_W,
    parameter int JOW   = JUMP_OFS_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AW-1:0]             pc_i,
    input  logic [KIND_W-1:0]         kind_i,
    input  logic [max_int(COW,JOW)-1:0] offset_i,
    input  logic [FLAG_W-1:0]         flags_i,
    output logic [AW-1:0]             next_pc_o,
    output logic                      taken_o
);
    localparam int OFS_W    = max_int(COW, JOW);
    localparam int ALIGN_SH = $clog2(IB);
    localparam logic [AW-1:0] ALIGN_MASK = AW'((1 << ALIGN_SH) - 1);
    localparam logic [AW-1:0] STEP       = AW'(IB);

    br_kind_e  kind;
    ccr_t      ccr;
    logic      is_cond, cond_ok, is_jump, take;
    logic [AW-1:0] pc_base, seq_pc, cond_disp, jump_disp, disp, target;
    npc_res_t  res_d, res_q;

    assign kind    = br_kind_e'(kind_i);
    assign ccr     = ccr_t'(flags_i);
    assign pc_base = pc_i & ~ALIGN_MASK;
    assign is_jump = (kind == BK_ALWAYS);

    pcb_cond_unit u_cond (
        .kind    (kind),
        .ccr     (ccr),
        .is_cond (is_cond),
        .cond_ok (cond_ok)
    );

    pcb_offset_scaler #(.IN_W(COW), .SHIFT(ALIGN_SH), .OUT_W(AW)) u_cond_ofs (
        .ofs_words (offset_i[COW-1:0]),
        .ofs_bytes (cond_disp)
    );

    pcb_offset_scaler #(.IN_W(JOW), .SHIFT(ALIGN_SH), .OUT_W(AW)) u_jump_ofs (
        .ofs_words (offset_i[JOW-1:0]),
        .ofs_bytes (jump_disp)
    );

    pcb_addr_adder #(.W(AW)) u_seq_add (
        .a   (pc_base),
        .b   (STEP),
        .sum (seq_pc)
    );

    assign disp = is_jump ? jump_disp : cond_disp;

    pcb_addr_adder #(.W(AW)) u_tgt_add (
        .a   (seq_pc),
        .b   (disp),
        .sum (target)
    );

    assign take = is_jump || (is_cond && cond_ok);

    always_comb begin
        res_d.taken = take;
        res_d.pc    = (take ? target : seq_pc) & ~ALIGN_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign next_pc_o = res_q.pc;
    assign taken_o   = res_q.taken;

    p_even_out_r9: assert property (@(posedge clk) disable iff (rst)
        next_pc_o[0] == 1'b0);

    p_seq_nonbranch_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_jump && !is_cond) |=>
            (!taken_o && next_pc_o == AW'(($past(pc_i) & ~ALIGN_MASK) + STEP)));

    p_jump_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 4'd13) |=> taken_o);

    p_eq_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 4'd1) |=> (taken_o == $past(flags_i[2])));

    p_fail_seq_r8: assert property (@(posedge clk) disable iff (rst)
        (is_cond && !cond_ok) |=> (!taken_o && next_pc_o == $past(seq_pc)));
endmodule

// File: tb/tb_pcb_next_pc.sv
module tb_pcb_next_pc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc_i = '0;
    logic [3:0]  kind_i = '0;
    logic [9:0]  offset_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] next_pc_o;
    logic        taken_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int    q_pc[$];
    bit    q_tk[$];
    string q_req[$];

    always #10 clk = ~clk;

    pcb_next_pc dut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .kind_i(kind_i),
        .offset_i(offset_i), .flags_i(flags_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o)
    );

    function automatic bit ref_cond(input int k, input int f);
        bit n = f[3], z = f[2], v = f[1], c = f[0];
        case (k)
            1:  return z;
            2:  return !z;
            3:  return c;
            4:  return !c;
            5:  return n;
            6:  return !n;
            7:  return v;
            8:  return !v;
            9:  return n == v;
            10: return n != v;
            11: return !z && (n == v);
            12: return z || (n != v);
            13: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int ref_words(input int k, input int ofs);
        int w;
        if (k == 13) begin
            w = ofs & 1023;
            if (w >= 512) w -= 1024;
        end else begin
            w = ofs & 511;
            if (w >= 256) w -= 512;
        end
        return w;
    endfunction

    task automatic check_now();
        int    epc;
        bit    etk;
        string req;
        if (q_pc.size() == 0) return;
        epc = q_pc.pop_front();
        etk = q_tk.pop_front();
        req = q_req.pop_front();
        checks++;
        if (next_pc_o !== 16'(epc) || taken_o !== etk) begin
            errors++;
            $display("FAIL %s: next_pc=%h taken=%0b expected next_pc=%h taken=%0b",
                     req, next_pc_o, taken_o, 16'(epc), etk);
        end
    endtask

    task automatic step(input int pc, input int k, input int ofs,
                        input int f, input string req);
        int seq, tgt;
        bit tk;
        @(negedge clk);
        check_now();
        pc_i = 16'(pc); kind_i = 4'(k); offset_i = 10'(ofs); flags_i = 4'(f);
        seq = ((pc & 'hFFFE) + 2) & 'hFFFF;
        tk  = ref_cond(k, f);
        tgt = (seq + 2 * ref_words(k, ofs)) & 'hFFFF;
        q_pc.push_back(tk ? tgt : seq);
        q_tk.push_back(tk);
        q_req.push_back(req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pc_i = 16'h1234; kind_i = 4'd13; offset_i = 10'h1FF; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset value
        checks++;
        if (next_pc_o !== 16'h0 || taken_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: next_pc=%h taken=%0b expected next_pc=0000 taken=0",
                     next_pc_o, taken_o);
        end
        rst = 1'b0;
        // R2: non-branch codes
        step('h0100, 0, 'h3FF, 'hF, "R2");
        step('h0200, 14, 'h005, 'h4, "R2");
        step('h0300, 15, 'h100, 'h0, "R2");
        // R3: conditional range limits and ignored bit 9
        step('h1000, 1, 'h0FF, 'h4, "R3");
        step('h1000, 1, 'h100, 'h4, "R3");
        step('h1000, 1, 'h2FF, 'h4, "R3");
        step('h1000, 2, 'h301, 'h0, "R3");
        // R4: unconditional range limits, flags irrelevant
        step('h2000, 13, 'h1FF, 'h0, "R4");
        step('h2000, 13, 'h200, 'hF, "R4");
        step('h2000, 13, 'h3FF, 'h5, "R4");
        // R5 to R8: every condition code against every flag pattern
        for (int k = 1; k <= 12; k++) begin
            for (int f = 0; f < 16; f++) begin
                step('h4000 + 16 * k, k, 'h010, f,
                     (k <= 2) ? "R5" : (k <= 8) ? "R6" : "R7");
            end
        end
        step('h5000, 1, 'h040, 'h0, "R8");
        step('h5000, 11, 'h040, 'h4, "R8");
        // R9: odd PC
        step('h0101, 0, 0, 0, "R9");
        step('h0101, 13, 'h002, 0, "R9");
        step('h0FFF, 2, 'h1FF, 0, "R9");
        // R10: wrap in both directions
        step('hFFFE, 0, 0, 0, "R10");
        step('hFFF0, 13, 'h010, 0, "R10");
        step('h0004, 13, 'h3F0, 0, "R10");
        step('h0002, 5, 'h1F0, 'h8, "R10");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(0, 65535)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 1023)), int'($urandom_range(0, 15)), "R3");
        end
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule